// File: doc/BRIEF.md
# Bounded Segment Register Unit

This block keeps the four 16-bit segment registers of a real-mode style processor and turns a register index plus a 16-bit offset into a physical address. The address is the segment value times sixteen (one paragraph per segment step) plus the offset. An address-line-20 gate input chooses whether that sum wraps at 1 MiB or passes through as a 21-bit value.

The block also has a single privilege bit with two settings, free and limited. In free mode the segment registers behave as on an unprotected processor: absolute loads, add and subtract all complete, and nothing traps. In limited mode code may move a segment register only by relative steps, and only inside an inclusive window `[lower, upper]` kept for each register. The window is written from free mode only. A forbidden absolute write, or a step that leaves the window, changes no register. Instead it returns the unit to free mode and raises a one-cycle trap strobe that carries a cause and the register index. A supervisor can use this, for example, to page in the region that a segment is moving into before it retries.

Commands enter through a valid/ready port. `cmd_ready` is tied high because every command completes in the cycle it is accepted, so the port never applies back-pressure. A command is taken on each rising edge where `cmd_valid` is high. The address path is purely combinational.

Top module: `seg_bound_unit`

## Requirements
- R1: `phys_addr` equals `seg[addr_sel]*16 + addr_off`, combinationally. Segment 1 with offset 0x0000 gives the same address as segment 0 with offset 0x0010.
- R2: When `a20_en` is 0, bit 20 of `phys_addr` is 0, so the sum wraps modulo 1 MiB. When `a20_en` is 1, the full 21-bit sum appears.
- R3: After reset the unit is in free mode (`user_mode`=0), every segment reads 0, every lower limit is 0x0000 and every upper limit is 0xFFFF.
- R4: In free mode, LOAD (op 1) writes `cmd_data`. ADD (op 2) and SUB (op 3) add or subtract `cmd_data` modulo 2^16. None of these traps.
- R5: In limited mode, LOAD traps with cause 1 (privileged write) and leaves the segment unchanged.
- R6: In limited mode, an ADD or SUB whose result lies inside the register's inclusive window is performed and does not trap.
- R7: In limited mode, an ADD with a 16-bit carry out traps with cause 3 (above upper) and leaves the segment unchanged. So does an ADD or SUB without carry or borrow whose result is greater than the upper limit; this check takes priority over the lower-limit check.
- R8: In limited mode, a SUB with a borrow traps with cause 2 (below lower). So does a step without carry or borrow, not already above the upper limit, whose result is less than the lower limit. In both cases the segment is unchanged.
- R9: A trap raises `trap_pulse` for exactly the one cycle after the command's edge, with `trap_cause` and `trap_sel` set. In the same cycle `user_mode` reads 0.
- R10: SETLIM (op 4) in free mode sets the lower limit from `cmd_data` and the upper limit from `cmd_hi`. SETMODE (op 5) in free mode sets `user_mode` to `cmd_data[0]`. In limited mode both ops trap with cause 1 and change nothing.
- R11: `cmd_ready` is always 1. Op codes 0, 6 and 7 change nothing and never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always 1; commands never stall |
| cmd_op | input | 3 | 0 NOP, 1 LOAD, 2 ADD, 3 SUB, 4 SETLIM, 5 SETMODE |
| cmd_sel | input | 2 | Segment index: 0 ES, 1 CS, 2 SS, 3 DS |
| cmd_data | input | 16 | Load value, step amount, lower limit, or mode in bit 0 |
| cmd_hi | input | 16 | Upper limit for SETLIM |
| a20_en | input | 1 | Address-line-20 gate |
| addr_sel | input | 2 | Segment index for address forming |
| addr_off | input | 16 | Offset within segment |
| phys_addr | output | 21 | Formed physical address |
| user_mode | output | 1 | 1 = limited mode |
| trap_pulse | output | 1 | One-cycle trap strobe |
| trap_cause | output | 2 | 1 privileged write, 2 below lower, 3 above upper |
| trap_sel | output | 2 | Index of the segment that trapped |

## Verification
The assertions assume that `cmd_op` carries only the six defined codes or the ignored spares, and that `cmd_valid` is never unknown after reset. They also assume that limits are programmed with lower not greater than upper, so that a step cannot be both above and below. The random stimulus draws op codes from the full 3-bit range, programs windows only with ordered bounds, and keeps step sizes small so that in-window, edge and out-of-window cases all occur. Directed cases cover carry, borrow, exact-boundary steps and the segment 1 versus offset 0x10 alias.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 16;
  localparam int NSEG  = 4;
  localparam int IDX_W = $clog2(NSEG);

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_LOAD    = 3'd1,
    OP_ADD     = 3'd2,
    OP_SUB     = 3'd3,
    OP_SETLIM  = 3'd4,
    OP_SETMODE = 3'd5
  } seg_op_e;

  typedef enum logic [1:0] {
    TC_NONE  = 2'd0,
    TC_PRIV  = 2'd1,
    TC_BELOW = 2'd2,
    TC_ABOVE = 2'd3
  } trap_cause_e;
endpackage

// File: rtl/seg_step_check.sv
module seg_step_check
  import seg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         is_sub,
  input  logic         limited,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] amt,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt,
  output trap_cause_e  cause
);
  logic [W:0] wide;
  logic       over, under;

  always_comb begin
    wide  = is_sub ? ({1'b0, cur} - {1'b0, amt}) : ({1'b0, cur} + {1'b0, amt});
    nxt   = wide[W-1:0];
    over  = (!is_sub && wide[W]) || (!wide[W] && (wide[W-1:0] > hi));
    under = (is_sub && wide[W])  || (!wide[W] && (wide[W-1:0] < lo));
    if (!limited)   cause = TC_NONE;
    else if (over)  cause = TC_ABOVE;
    else if (under) cause = TC_BELOW;
    else            cause = TC_NONE;
  end
endmodule

// File: rtl/seg_phys_addr.sv
module seg_phys_addr #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             wide_en,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] sum;

  always_comb begin
    sum = {1'b0, seg, {SHIFT{1'b0}}} + PA_W'(off);
    pa  = wide_en ? sum : {1'b0, sum[PA_W-2:0]};
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_en |-> !pa[PA_W-1]) else $error("address bit 20 set with gate low"); // R2
endmodule

// File: rtl/seg_bound_unit.sv
module seg_bound_unit
  import seg_pkg::*;
#(
  parameter int SW  = 16,
  parameter int OW  = 16,
  parameter int SH  = 4,
  parameter int NS  = 4,
  localparam int IW = $clog2(NS),
  localparam int PW = SW + SH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_sel,
  input  logic [SW-1:0] cmd_data,
  input  logic [SW-1:0] cmd_hi,
  input  logic          a20_en,
  input  logic [IW-1:0] addr_sel,
  input  logic [OW-1:0] addr_off,
  output logic [PW-1:0] phys_addr,
  output logic          user_mode,
  output logic          trap_pulse,
  output logic [1:0]    trap_cause,
  output logic [IW-1:0] trap_sel
);
  logic [NS-1:0][SW-1:0] seg_q, lo_q, hi_q;
  logic [SW-1:0]         step_nxt;
  trap_cause_e           step_cause, cause_d;
  logic                  is_step, is_priv;

  assign cmd_ready = 1'b1;

  seg_step_check #(.W(SW)) u_chk (
    .is_sub (cmd_op == OP_SUB),
    .limited(user_mode),
    .cur    (seg_q[cmd_sel]),
    .amt    (cmd_data),
    .lo     (lo_q[cmd_sel]),
    .hi     (hi_q[cmd_sel]),
    .nxt    (step_nxt),
    .cause  (step_cause)
  );

  always_comb begin
    is_step = (cmd_op == OP_ADD) || (cmd_op == OP_SUB);
    is_priv = (cmd_op == OP_LOAD) || (cmd_op == OP_SETLIM) || (cmd_op == OP_SETMODE);
    if (!cmd_valid)             cause_d = TC_NONE;
    else if (user_mode && is_priv) cause_d = TC_PRIV;
    else if (is_step)           cause_d = step_cause;
    else                        cause_d = TC_NONE;
  end

  for (genvar g = 0; g < NS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
        lo_q[g]  <= '0;
        hi_q[g]  <= '1;
      end else if (cmd_valid && cmd_sel == IW'(g) && cause_d == TC_NONE) begin
        if (cmd_op == OP_LOAD)  seg_q[g] <= cmd_data;
        if (is_step)            seg_q[g] <= step_nxt;
        if (cmd_op == OP_SETLIM) begin
          lo_q[g] <= cmd_data;
          hi_q[g] <= cmd_hi;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_mode  <= 1'b0;
      trap_pulse <= 1'b0;
      trap_cause <= 2'd0;
      trap_sel   <= '0;
    end else begin
      trap_pulse <= (cause_d != TC_NONE);
      trap_cause <= cause_d;
      trap_sel   <= cmd_sel;
      if (cause_d != TC_NONE)
        user_mode <= 1'b0;
      else if (cmd_valid && cmd_op == OP_SETMODE)
        user_mode <= cmd_data[0];
    end
  end

  seg_phys_addr #(.SEG_W(SW), .OFF_W(OW), .SHIFT(SH)) u_pa (
    .clk    (clk),
    .rst_n  (rst_n),
    .seg    (seg_q[addr_sel]),
    .off    (addr_off),
    .wide_en(a20_en),
    .pa     (phys_addr)
  );

  AST_TRAP_FREE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> !user_mode) else $error("mode still limited after trap"); // R9
  AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> !trap_pulse) else $error("trap strobe longer than one cycle"); // R9
  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (seg_q == $past(seg_q) && lo_q == $past(lo_q) && hi_q == $past(hi_q)))
    else $error("state changed on trapping command"); // R7
  AST_LOAD_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && user_mode && cmd_op == OP_LOAD) |=> (trap_pulse && trap_cause == 2'd1))
    else $error("limited load did not trap"); // R5
  AST_FREE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !user_mode) |=> !trap_pulse) else $error("trap from free mode"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!trap_pulse && $stable(seg_q))) else $error("change without command"); // R11
endmodule

// File: tb/seg_bound_unit_test.sv
module seg_bound_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_sel = '0;
  logic [15:0] cmd_data = '0, cmd_hi = '0;
  logic        a20_en = 1'b1;
  logic [1:0]  addr_sel = '0;
  logic [15:0] addr_off = '0;
  logic [20:0] phys_addr;
  logic        user_mode, trap_pulse;
  logic [1:0]  trap_cause, trap_sel;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] m_seg [4], m_lo [4], m_hi [4];
  logic        m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_bound_unit uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_pa(input logic [15:0] s, input logic [15:0] o, input logic g);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return g ? t : {1'b0, t[19:0]};
  endfunction

  task automatic check_addr(input logic [1:0] sel, input logic [15:0] off, input logic g, input string req);
    addr_sel = sel; addr_off = off; a20_en = g;
    #1;
    check(phys_addr == exp_pa(m_seg[sel], off, g), req, 32'(phys_addr), 32'(exp_pa(m_seg[sel], off, g)));
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cmd(input logic [2:0] op, input logic [1:0] sel, input logic [15:0] d,
                     input logic [15:0] h, input string req);
    logic [1:0]  ec;
    logic [16:0] w;
    logic [15:0] nv;
    ec = 2'd0; nv = m_seg[sel];
    case (op)
      3'd1: if (m_mode) ec = 2'd1; else nv = d;
      3'd2, 3'd3: begin
        w = (op == 3'd3) ? ({1'b0, m_seg[sel]} - {1'b0, d}) : ({1'b0, m_seg[sel]} + {1'b0, d});
        nv = w[15:0];
        if (m_mode) begin
          if ((op == 3'd2 && w[16]) || (!w[16] && w[15:0] > m_hi[sel])) ec = 2'd3;
          else if ((op == 3'd3 && w[16]) || (!w[16] && w[15:0] < m_lo[sel])) ec = 2'd2;
        end
      end
      3'd4, 3'd5: if (m_mode) ec = 2'd1;
      default: ;
    endcase
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_hi = h;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(trap_pulse == (ec != 0), req, 32'(trap_pulse), 32'(ec != 0));
    if (ec != 0) begin
      check(trap_cause == ec && trap_sel == sel, req, {trap_cause, trap_sel}, {ec, sel});
      m_mode = 1'b0;
    end else begin
      if (op == 3'd1 || op == 3'd2 || op == 3'd3) m_seg[sel] = nv;
      if (op == 3'd4) begin m_lo[sel] = d; m_hi[sel] = h; end
      if (op == 3'd5) m_mode = d[0];
    end
    check(user_mode == m_mode, req, 32'(user_mode), 32'(m_mode));
    check_addr(sel, 16'h0, 1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    for (int i = 0; i < 4; i++) begin m_seg[i] = 0; m_lo[i] = 0; m_hi[i] = 16'hFFFF; end
    m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    check(!user_mode && !trap_pulse && cmd_ready, "R3", {user_mode, trap_pulse, cmd_ready}, 3'b001);
    for (int i = 0; i < 4; i++) check_addr(2'(i), 16'h0, 1'b1, "R3");
    // R3 default limits: limited mode can step to the top and bottom
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd2, 0, 16'hFFFF, 0, "R3");
    cmd(3'd3, 0, 16'hFFFF, 0, "R3");
    cmd(3'd5, 0, 16'h0, 0, "R10");  // traps: privileged in limited mode
    // R1 alias and R2 gate
    cmd(3'd1, 1, 16'h0001, 0, "R4");
    check_addr(1, 16'h0000, 1'b1, "R1");
    check(phys_addr == 21'h10, "R1", 32'(phys_addr), 32'h10);
    check_addr(0, 16'h0010, 1'b1, "R1");
    check(phys_addr == 21'h10, "R1", 32'(phys_addr), 32'h10);
    cmd(3'd1, 2, 16'hFFFF, 0, "R4");
    check_addr(2, 16'hFFFF, 1'b0, "R2");
    check_addr(2, 16'hFFFF, 1'b1, "R2");
    // R4 free-mode wrap
    cmd(3'd2, 2, 16'h0003, 0, "R4");
    cmd(3'd3, 3, 16'h0001, 0, "R4");
    // R10 limits, then R6/R7/R8 boundaries
    cmd(3'd1, 3, 16'h0100, 0, "R4");
    cmd(3'd4, 3, 16'h0080, 16'h0180, "R10");
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd2, 3, 16'h0080, 0, "R6");   // exactly upper
    cmd(3'd2, 3, 16'h0001, 0, "R7");   // above
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd3, 3, 16'h0100, 0, "R6");   // exactly lower
    cmd(3'd3, 3, 16'h0001, 0, "R8");   // below
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd1, 3, 16'h0123, 0, "R5");
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd4, 3, 16'h0000, 16'h0001, "R10");
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd6, 3, 16'hFFFF, 0, "R11");
    cmd(3'd0, 3, 16'hFFFF, 0, "R11");
    // R7 carry and R8 borrow with full window
    cmd(3'd4, 1, 16'h0000, 16'hFFFF, "R10");
    cmd(3'd1, 1, 16'hFFF0, 0, "R4");
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd2, 1, 16'h0020, 0, "R7");
    cmd(3'd4, 0, 16'h0000, 16'hFFFF, "R10");
    cmd(3'd5, 0, 16'h1, 0, "R10");
    cmd(3'd3, 0, 16'h0001, 0, "R8");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] op; logic [1:0] s; logic [15:0] a, b;
      op = 3'($urandom_range(0, 7));
      s  = 2'($urandom);
      a  = 16'($urandom);
      b  = 16'($urandom);
      if (op == 3'd2 || op == 3'd3) a = 16'($urandom_range(0, 64));
      if (op == 3'd4) begin
        if (a > b) begin logic [15:0] t; t = a; a = b; b = t; end
      end
      cmd(op, s, a, b, "R6");
      check_addr(2'($urandom), 16'($urandom), 1'($urandom), "R1");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule